// File: doc/BRIEF.md
# Chip Reset Sequencing Controller

This block orders the reset of a system-on-chip from a single reference clock. It has two sequences. A cold start is driven by the active-low power-on input. It holds every reset domain and the PLLs, captures the configuration straps once, releases the PLLs and starts full initialization. Once initialization and PLL lock are both reported, it gates the system clocks for a fixed pause and restarts them with their dividers reloaded. It then lets the chip run, but only when the external reset pin is also released.

A warm reset can come from four initiators: the external pin (after a minimum low time), a software write, the watchdog and the emulator. A small configuration input turns each of the first three into a soft reset, which clears only the soft domain. The emulator always causes a hard reset. A warm reset leaves the PLLs and the clocks alone. When the source releases, a shortened initialization runs before the status pin goes high again. A fresh request during a warm sequence restarts it. The power-on input overrides everything.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While pwr_on_rst_n is low, the outputs are held in reset. rst_stat_n=0, full_rst_n=0, hard_rst_n=0 and soft_rst_n=0. pll_rst=1 and pad_hiz=1. strap_stb, init_run, init_short and div_load are 0, and clk_en=1. Assertion of pwr_on_rst_n acts at once; its release passes through a two-flop synchronizer.
- R2: strap_stb pulses for exactly one cycle, on the third rising clock edge after pwr_on_rst_n rises. strap_val takes strap_in on the following edge and holds it until the next power-on release. Warm resets do not change it.
- R3: One cycle after the strap strobe, pll_rst falls and init_run rises with init_short=0.
- R4: On the edge where init_done and pll_locked are both 1 during full initialization, clk_en drops for exactly PAUSE_CYC (10) cycles. Then div_load is 1 for one cycle with clk_en=1.
- R5: After the reload cycle, full_rst_n and rst_stat_n go high only once the synchronized external pin reads high. A pin still held low keeps the chip in reset.
- R6: A low level on ext_rst_n triggers a warm reset only once it has been sampled low on MIN_LOW_CYC (24) consecutive edges. Shorter pulses have no effect.
- R7: cfg_soft bit 0 selects soft for the pin, bit 1 for the software write and bit 2 for the watchdog. A 0 bit means hard. emu_req always gives a hard reset. If hard and soft requests arrive together, the result is hard.
- R8: A hard reset drives hard_rst_n=0, soft_rst_n=0 and pad_hiz=1. A soft reset drives only soft_rst_n=0. Neither changes full_rst_n, pll_rst or clk_en.
- R9: During a warm reset rst_stat_n is 0. The hold lasts while a request is present or the external pin reads low. Then a short initialization (init_run=1, init_short=1) runs until init_done, and rst_stat_n returns high.
- R10: A request during a warm hold or short initialization restarts the hold. The kind becomes hard if either the running sequence or the new request is hard.
- R11: Warm reset requests are ignored during the power-on sequence. Driving pwr_on_rst_n low at any time returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_on_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External warm reset pin, active low, asynchronous |
| wdog_req | input | 1 | Watchdog reset request |
| emu_req | input | 1 | Emulation reset request (always hard) |
| sw_rst_wr | input | 1 | Software reset-control write strobe |
| cfg_soft | input | 3 | Soft select: bit0 pin, bit1 software, bit2 watchdog |
| pll_locked | input | 1 | All chip PLLs report lock |
| init_done | input | 1 | Device initialization finished |
| strap_in | input | STRAP_W | Configuration strap pins |
| rst_stat_n | output | 1 | Reset status, low while the chip is in reset |
| strap_stb | output | 1 | One-cycle strap capture strobe |
| strap_val | output | STRAP_W | Captured strap values |
| full_rst_n | output | 1 | Reset for logic cleared only by power-on |
| hard_rst_n | output | 1 | Hard-reset domain reset |
| soft_rst_n | output | 1 | Soft-reset domain reset |
| pll_rst | output | 1 | PLL reset |
| init_run | output | 1 | Initialization request |
| init_short | output | 1 | Initialization is the shortened warm form |
| clk_en | output | 1 | System clock gate enable |
| div_load | output | 1 | Reload default clock dividers |
| pad_hiz | output | 1 | Tri-state the affected pads |

## Verification
Every port is a pure decode of the sequencer state, the warm-reset kind and the strap register. A wrong state therefore shows on the ports in the same cycle. A phase entered early or late moves rst_stat_n, clk_en, div_load or init_short by at least one cycle. A wrong kind shows at once as hard_rst_n or pad_hiz disagreeing with soft_rst_n. A miscount in the pin filter shows about 24 cycles later, as a warm reset that happens or does not. The bench runs an independent cycle model and compares all outputs on every clock.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [3:0] {
    S_POR    = 4'd0,
    S_LATCH  = 4'd1,
    S_INIT   = 4'd2,
    S_PAUSE  = 4'd3,
    S_RELOAD = 4'd4,
    S_EXTW   = 4'd5,
    S_RUN    = 4'd6,
    S_HOLD   = 4'd7,
    S_SINIT  = 4'd8
  } rsq_state_e;

  typedef struct packed {
    logic any;
    logic hard;
  } rsq_req_t;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[LAST-1:0], 1'b1};
    end
  end

  assign q = sh_q[LAST];

endmodule

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
  parameter int MIN_LOW_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ok,
  output logic pin_hold
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (ext_ok) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CMAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pin_hold = !ext_ok && (cnt_q == CMAX);

  // R6
  pin_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hold |-> $past(!ext_ok));

endmodule

// File: rtl/rsq_src_decode.sv
module rsq_src_decode
  import rsq_pkg::*;
#(
  parameter int NCFG = 3
) (
  input  logic            pin_ev,
  input  logic            sw_ev,
  input  logic            wdog_ev,
  input  logic            emu_ev,
  input  logic [NCFG-1:0] cfg_soft,
  output rsq_req_t        req
);
  logic [NCFG-1:0] ev;
  logic [NCFG-1:0] hard_v;

  assign ev = {wdog_ev, sw_ev, pin_ev};

  for (genvar g = 0; g < NCFG; g++) begin : g_kind
    assign hard_v[g] = ev[g] & ~cfg_soft[g];
  end

  assign req.any  = (|ev) | emu_ev;
  assign req.hard = (|hard_v) | emu_ev;

endmodule

// File: rtl/rsq_seq_fsm.sv
module rsq_seq_fsm
  import rsq_pkg::*;
#(
  parameter int PAUSE_CYC = 10,
  parameter int STRAP_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_ok,
  input  logic               pll_locked,
  input  logic               init_done,
  input  rsq_req_t           req,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               rst_stat_n,
  output logic               strap_stb,
  output logic [STRAP_W-1:0] strap_val,
  output logic               full_rst_n,
  output logic               hard_rst_n,
  output logic               soft_rst_n,
  output logic               pll_rst,
  output logic               init_run,
  output logic               init_short,
  output logic               clk_en,
  output logic               div_load,
  output logic               pad_hiz
);
  localparam int PCW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam logic [PCW-1:0] PLAST = PCW'(PAUSE_CYC - 1);

  rsq_state_e         st_q, st_d;
  logic               kind_q, kind_d;
  logic [PCW-1:0]     pcnt_q, pcnt_d;
  logic               pcnt_en;
  logic [STRAP_W-1:0] strap_q;
  logic               strap_en;
  logic               warm;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    pcnt_d   = pcnt_q;
    pcnt_en  = 1'b0;
    strap_en = 1'b0;
    unique case (st_q)
      S_POR:   st_d = S_LATCH;
      S_LATCH: begin
        strap_en = 1'b1;
        st_d     = S_INIT;
      end
      S_INIT: begin
        if (pll_locked && init_done) begin
          st_d    = S_PAUSE;
          pcnt_d  = '0;
          pcnt_en = 1'b1;
        end
      end
      S_PAUSE: begin
        if (pcnt_q == PLAST) begin
          st_d = S_RELOAD;
        end else begin
          pcnt_d  = pcnt_q + 1'b1;
          pcnt_en = 1'b1;
        end
      end
      S_RELOAD: st_d = ext_ok ? S_RUN : S_EXTW;
      S_EXTW:   if (ext_ok) st_d = S_RUN;
      S_RUN: begin
        if (req.any) begin
          st_d   = S_HOLD;
          kind_d = req.hard;
        end
      end
      S_HOLD: begin
        if (req.any) begin
          kind_d = kind_q | req.hard;
        end else if (ext_ok) begin
          st_d = S_SINIT;
        end
      end
      S_SINIT: begin
        if (req.any) begin
          st_d   = S_HOLD;
          kind_d = kind_q | req.hard;
        end else if (init_done) begin
          st_d = S_RUN;
        end
      end
      default: st_d = S_POR;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_POR;
      kind_q  <= 1'b0;
      pcnt_q  <= '0;
      strap_q <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      if (pcnt_en) begin
        pcnt_q <= pcnt_d;
      end
      if (strap_en) begin
        strap_q <= strap_in;
      end
    end
  end

  // output decode
  assign warm       = (st_q == S_HOLD) || (st_q == S_SINIT);
  assign rst_stat_n = (st_q == S_RUN);
  assign full_rst_n = (st_q == S_RUN) || warm;
  assign hard_rst_n = (st_q == S_RUN) || (warm && !kind_q);
  assign soft_rst_n = (st_q == S_RUN);
  assign pll_rst    = (st_q == S_POR) || (st_q == S_LATCH);
  assign strap_stb  = (st_q == S_LATCH);
  assign strap_val  = strap_q;
  assign init_run   = (st_q == S_INIT) || (st_q == S_SINIT);
  assign init_short = (st_q == S_SINIT);
  assign clk_en     = (st_q != S_PAUSE);
  assign div_load   = (st_q == S_RELOAD);
  assign pad_hiz    = (st_q == S_POR) || ((st_q == S_HOLD) && kind_q);

  // R4
  reload_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> ($past(!clk_en) && clk_en));

  // R4
  pause_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RELOAD) |-> ($past(pcnt_q) == PLAST));

  // R3
  pll_after_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> ($past(strap_stb) && init_run));

  // R8
  soft_covers_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hard_rst_n |-> !soft_rst_n);

  // R5
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_rst_n) |-> $past(ext_ok));

  // R8
  warm_keeps_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_rst_n |-> (clk_en && !pll_rst));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int STRAP_W     = 8,
  parameter int MIN_LOW_CYC = 24,
  parameter int PAUSE_CYC   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               pwr_on_rst_n,
  input  logic               ext_rst_n,
  input  logic               wdog_req,
  input  logic               emu_req,
  input  logic               sw_rst_wr,
  input  logic [2:0]         cfg_soft,
  input  logic               pll_locked,
  input  logic               init_done,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               rst_stat_n,
  output logic               strap_stb,
  output logic [STRAP_W-1:0] strap_val,
  output logic               full_rst_n,
  output logic               hard_rst_n,
  output logic               soft_rst_n,
  output logic               pll_rst,
  output logic               init_run,
  output logic               init_short,
  output logic               clk_en,
  output logic               div_load,
  output logic               pad_hiz
);
  logic     rst_i;
  logic     ext_ok;
  logic     pin_hold;
  rsq_req_t req;

  rsq_sync #(.STAGES(SYNC_STAGES)) i_por_sync (
    .clk    (clk),
    .arst_n (pwr_on_rst_n),
    .q      (rst_i)
  );

  rsq_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
    .clk    (clk),
    .arst_n (ext_rst_n),
    .q      (ext_ok)
  );

  rsq_pin_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) i_pin_filter (
    .clk      (clk),
    .rst_n    (rst_i),
    .ext_ok   (ext_ok),
    .pin_hold (pin_hold)
  );

  rsq_src_decode #(.NCFG(3)) i_src_decode (
    .pin_ev   (pin_hold),
    .sw_ev    (sw_rst_wr),
    .wdog_ev  (wdog_req),
    .emu_ev   (emu_req),
    .cfg_soft (cfg_soft),
    .req      (req)
  );

  rsq_seq_fsm #(.PAUSE_CYC(PAUSE_CYC), .STRAP_W(STRAP_W)) i_seq_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .ext_ok     (ext_ok),
    .pll_locked (pll_locked),
    .init_done  (init_done),
    .req        (req),
    .strap_in   (strap_in),
    .rst_stat_n (rst_stat_n),
    .strap_stb  (strap_stb),
    .strap_val  (strap_val),
    .full_rst_n (full_rst_n),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .pll_rst    (pll_rst),
    .init_run   (init_run),
    .init_short (init_short),
    .clk_en     (clk_en),
    .div_load   (div_load),
    .pad_hiz    (pad_hiz)
  );

  // R7
  emu_always_hard_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (rst_stat_n && emu_req) |=> !hard_rst_n);

  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !$past(strap_stb) |-> $stable(strap_val));

  // R1
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(strap_stb) |-> (pll_rst && !rst_stat_n && !full_rst_n));

endmodule

// File: tb/test_rst_seq_ctrl.sv
`timescale 1ns/1ps
module test_rst_seq_ctrl;
  localparam int SW   = 8;
  localparam int MINL = 24;
  localparam int PZ   = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          por_n, ext_n, wdog, emu, swr, pll, idone;
  logic [2:0]    cfg;
  logic [SW-1:0] strap;
  logic          rst_stat_n, strap_stb, full_rst_n, hard_rst_n, soft_rst_n;
  logic          pll_rst, init_run, init_short, clk_en, div_load, pad_hiz;
  logic [SW-1:0] strap_val;

  rst_seq_ctrl #(.STRAP_W(SW), .MIN_LOW_CYC(MINL), .PAUSE_CYC(PZ)) i_rst_seq_ctrl (
    .clk(clk), .pwr_on_rst_n(por_n), .ext_rst_n(ext_n), .wdog_req(wdog),
    .emu_req(emu), .sw_rst_wr(swr), .cfg_soft(cfg), .pll_locked(pll),
    .init_done(idone), .strap_in(strap), .rst_stat_n(rst_stat_n),
    .strap_stb(strap_stb), .strap_val(strap_val), .full_rst_n(full_rst_n),
    .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n), .pll_rst(pll_rst),
    .init_run(init_run), .init_short(init_short), .clk_en(clk_en),
    .div_load(div_load), .pad_hiz(pad_hiz)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 por,1 latch,2 init,3 pause,4 reload,5 extwait,6 run,7 hold,8 short init
  bit m_p1, m_p2, m_e1, m_e2, m_hard;
  int m_lo, m_ph, m_pc;
  logic [SW-1:0] m_strap;
  bit eok, pin, any, hd;

  always @(posedge clk) begin
    eok  = ext_n ? m_e2 : 1'b0;
    m_e2 = ext_n ? m_e1 : 1'b0;
    m_e1 = ext_n;
    if (!por_n || !m_p2) begin
      m_lo = 0; m_ph = 0; m_pc = 0; m_hard = 0; m_strap = '0;
    end else begin
      pin = !eok && (m_lo == MINL);
      any = pin || swr || wdog || emu;
      hd  = (pin && !cfg[0]) || (swr && !cfg[1]) || (wdog && !cfg[2]) || emu;
      if (eok) m_lo = 0; else if (m_lo < MINL) m_lo++;
      case (m_ph)
        0: m_ph = 1;
        1: begin m_ph = 2; m_strap = strap; end
        2: if (pll && idone) begin m_ph = 3; m_pc = 0; end
        3: if (m_pc == PZ - 1) m_ph = 4; else m_pc++;
        4: m_ph = eok ? 6 : 5;
        5: if (eok) m_ph = 6;
        6: if (any) begin m_ph = 7; m_hard = hd; end
        7: if (any) m_hard = m_hard | hd; else if (eok) m_ph = 8;
        8: if (any) begin m_ph = 7; m_hard = m_hard | hd; end else if (idone) m_ph = 6;
        default: m_ph = 0;
      endcase
    end
    if (!por_n) begin m_p1 = 0; m_p2 = 0; end
    else begin m_p2 = m_p1; m_p1 = 1; end
  end

  // compare every clock, a little after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("R5", "rst_stat_n", rst_stat_n, m_ph == 6);
      check("R5", "full_rst_n", full_rst_n, m_ph >= 6);
      check("R8", "hard_rst_n", hard_rst_n, (m_ph == 6) || (m_ph >= 7 && !m_hard));
      check("R8", "soft_rst_n", soft_rst_n, m_ph == 6);
      check("R3", "pll_rst", pll_rst, m_ph <= 1);
      check("R2", "strap_stb", strap_stb, m_ph == 1);
      check("R2", "strap_val", strap_val, m_strap);
      check("R9", "init_run", init_run, m_ph == 2 || m_ph == 8);
      check("R9", "init_short", init_short, m_ph == 8);
      check("R4", "clk_en", clk_en, m_ph != 3);
      check("R4", "div_load", div_load, m_ph == 4);
      check("R1", "pad_hiz", pad_hiz, m_ph == 0 || (m_ph == 7 && m_hard));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    por_n = 0; ext_n = 0; wdog = 0; emu = 0; swr = 0; pll = 0; idone = 0;
    cfg = 3'b000; strap = 8'hA5;
    cyc(5);
    // R1 held state
    check("R1", "por rst_stat_n", rst_stat_n, 0);
    check("R1", "por pll_rst", pll_rst, 1);
    check("R1", "por pad_hiz", pad_hiz, 1);
    por_n = 1;
    cyc(4);
    // R11 watchdog during full init is ignored
    wdog = 1; cyc(1); wdog = 0;
    check("R11", "init_run during por seq", init_run, 1);
    strap = 8'h3C;
    cyc(3); pll = 1;
    cyc(4); idone = 1;
    cyc(20);
    // R5 pin still low keeps chip in reset
    check("R5", "rst_stat_n with pin low", rst_stat_n, 0);
    ext_n = 1;
    cyc(4);
    check("R5", "rst_stat_n released", rst_stat_n, 1);
    check("R2", "strap captured", strap_val, 8'hA5);
    // R6 short pulse ignored
    ext_n = 0; cyc(10); ext_n = 1; cyc(3);
    check("R6", "short pulse", rst_stat_n, 1);
    // R6 long pulse gives hard reset
    idone = 0; ext_n = 0; cyc(30);
    check("R6", "long pulse hard", hard_rst_n, 0);
    ext_n = 1; cyc(5);
    check("R9", "short init", init_short, 1);
    check("R9", "status low in short init", rst_stat_n, 0);
    idone = 1; cyc(3);
    check("R9", "status back high", rst_stat_n, 1);
    check("R2", "strap not recaptured", strap_val, 8'hA5);
    // R7 watchdog configured soft
    cfg = 3'b111; wdog = 1; cyc(1); wdog = 0;
    check("R7", "soft wdog soft_rst_n", soft_rst_n, 0);
    check("R7", "soft wdog hard_rst_n", hard_rst_n, 1);
    check("R8", "soft keeps pads", pad_hiz, 0);
    cyc(4);
    // R7 emulation is hard even with all soft bits
    emu = 1; cyc(1); emu = 0;
    check("R7", "emu hard", hard_rst_n, 0);
    check("R8", "hard pad_hiz", pad_hiz, 1);
    check("R8", "clk_en kept", clk_en, 1);
    cyc(4);
    // R7 software write with bit1 clear is hard
    cfg = 3'b100; swr = 1; cyc(1); swr = 0;
    check("R7", "sw hard", hard_rst_n, 0);
    cyc(4);
    // R10 soft sequence upgraded by a hard request
    idone = 0; wdog = 1; cyc(1); wdog = 0;
    check("R10", "soft start", hard_rst_n, 1);
    cyc(1);
    check("R10", "in short init", init_short, 1);
    swr = 1; cyc(1); swr = 0;
    check("R10", "restart hard", hard_rst_n, 0);
    check("R10", "restart hold", init_run, 0);
    idone = 1; cyc(4);
    check("R10", "run again", rst_stat_n, 1);
    // R11 power-on mid-run resets at once and recaptures straps
    strap = 8'h5A; por_n = 0; #1;
    check("R11", "async status", rst_stat_n, 0);
    check("R11", "async pll_rst", pll_rst, 1);
    cyc(3); por_n = 1;
    cyc(6);
    check("R2", "new straps", strap_val, 8'h5A);
    cyc(20);
    check("R4", "back in run", rst_stat_n, 1);
    finish_up();
  end

endmodule